// File: doc/BRIEF.md
# Two-Stage Prescaled Compare Timer

The block is a timer made of two counter stages. A prescaler stage counts clock-enable ticks that arrive on every second system clock cycle. When its count reaches a programmable reload value it returns to zero on the next tick and inverts an internal divide line. A main stage counts the rising edges of that line, so the main count rate is the system clock divided by 4·(RC+1). The main count is compared against three compare registers. Each time the count steps onto a compare value, a pending flag is set. The flags are gated by an interrupt mask and drive a single interrupt line.

Software reaches the block through a synchronous register port. That port covers start, stop and restart control for each stage, reload and compare writes, readback of both counters, a status register that clears when read, and a mask that is changed through separate write-one-to-set and write-one-to-clear addresses. Read data is combinational from the address. A read has a side effect only at the status address, and only in a cycle where `rd_en` is high at the clock edge.

Register addresses, 4-bit: 0 prescaler control, 1 reload, 2 prescaler count, 3 main control, 4+i compare i (i = 0..2), 7 main count, 8 status, 9 mask set, 10 mask clear, 11 mask readback. Control words: bit 0 start, bit 1 stop, bit 2 restart.

Top module: `chained_timer`

## Requirements
- R1: After reset both counters read 0, both stages are stopped, the status and mask registers read 0, and `irq` is low. A stopped main count does not change.
- R2: A running prescaler advances on every second system cycle after a restart. Its count reads 1, 2, ... at 2, 4, ... cycles after the restart edge and returns to 0 on the tick after it equals the reload value.
- R3: With a reload value of 0 the prescaler count stays 0 and the divide line inverts on every tick.
- R4: After a prescaler restart (control value 5, with the main stage already restarted), the main count first increments 2·(RC+1)+1 cycles after the restart edge. It then increments every 4·(RC+1) cycles.
- R5: Writing the restart bit (bit 2) to a control register zeroes that stage's count and starts it. Bit 0 starts a stopped stage without changing its count.
- R6: When the main count steps onto the value of compare register i (address 4+i), status bit i is set.
- R7: A status read (address 8) returns the pending flags and clears them. A flag that sets in the same cycle as the read stays set.
- R8: Writing 1 to bit i at address 9 sets mask bit i, and writing 1 at address 10 clears it. Zero bits leave the mask unchanged. The mask reads back at address 11.
- R9: `irq` is high exactly when some status bit and its mask bit are both 1.
- R10: Reading the main count, with or without `rd_en`, does not disturb counting.
- R11: The main count wraps from all ones to zero, and stepping onto zero matches a compare value of 0.
- R12: A control write with both start (bit 0) and stop (bit 1) set leaves the stage stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (side effect only at status) |
| addr | input | AW | Register address |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data for `addr` |
| irq | output | 1 | Masked compare interrupt |

## Verification
The bench is built with an 8-bit counter width, so that a wrap through zero takes about a thousand cycles. It measures the main count over windows of several lengths and reload values. An off-by-one in the reload match or in the edge detector would shift every expected count. It drives a status read in the exact cycle that a compare match lands. A design that lets the clear win would lose that flag. It also checks a start-plus-stop write, which must leave the stage frozen, and mask writes with zero bits, which must change nothing.

// File: rtl/chained_timer.sv
module chained_timer #(
  parameter int DW = 32,
  parameter int CW = 32,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          irq
);
  localparam int NCMP = 3;
  localparam logic [AW-1:0] A_PCTL = AW'(0);
  localparam logic [AW-1:0] A_RC   = AW'(1);
  localparam logic [AW-1:0] A_PCNT = AW'(2);
  localparam logic [AW-1:0] A_MCTL = AW'(3);
  localparam logic [AW-1:0] A_CMP  = AW'(4);
  localparam logic [AW-1:0] A_MCNT = AW'(7);
  localparam logic [AW-1:0] A_STAT = AW'(8);
  localparam logic [AW-1:0] A_MSET = AW'(9);
  localparam logic [AW-1:0] A_MCLR = AW'(10);
  localparam logic [AW-1:0] A_MASK = AW'(11);

  logic [CW-1:0]   pcnt, rc, mcnt;
  logic [CW-1:0]   cmp [NCMP];
  logic [NCMP-1:0] flags, mask, hit;
  logic            prun, mrun, ph, tog, tog_d;

  wire wr_pctl = wr_en && (addr == A_PCTL);
  wire wr_mctl = wr_en && (addr == A_MCTL);
  wire ptrig   = wr_pctl && wdata[2];
  wire mtrig   = wr_mctl && wdata[2];
  wire stat_rd = rd_en && (addr == A_STAT);
  wire ptick   = prun && ph;
  wire rise    = tog && !tog_d;
  wire mstep   = mrun && rise && !mtrig;
  wire [CW-1:0] mnext = mcnt + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pcnt <= '0; ph <= 1'b0; tog <= 1'b0; tog_d <= 1'b0; prun <= 1'b0; rc <= '0;
    end else begin
      tog_d <= tog;
      if (ptrig) begin
        pcnt <= '0; ph <= 1'b0; tog <= 1'b0;
      end else begin
        ph <= ~ph;
        if (ptick) begin
          if (pcnt == rc) begin
            pcnt <= '0;
            tog  <= ~tog;
          end else begin
            pcnt <= pcnt + 1'b1;
          end
        end
      end
      if (wr_pctl) begin
        if (wdata[1])                prun <= 1'b0;
        else if (wdata[0] | wdata[2]) prun <= 1'b1;
      end
      if (wr_en && addr == A_RC) rc <= wdata[CW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mcnt <= '0; mrun <= 1'b0;
    end else begin
      if (mtrig)      mcnt <= '0;
      else if (mstep) mcnt <= mnext;
      if (wr_mctl) begin
        if (wdata[1])                mrun <= 1'b0;
        else if (wdata[0] | wdata[2]) mrun <= 1'b1;
      end
    end
  end

  for (genvar i = 0; i < NCMP; i++) begin : g_cmp
    always_ff @(posedge clk) begin
      if (!rst_n) cmp[i] <= '0;
      else if (wr_en && addr == A_CMP + AW'(i)) cmp[i] <= wdata[CW-1:0];
    end
    assign hit[i] = mstep && (mnext == cmp[i]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags <= '0; mask <= '0;
    end else begin
      flags <= (stat_rd ? '0 : flags) | hit;
      if (wr_en && addr == A_MSET)      mask <= mask | wdata[NCMP-1:0];
      else if (wr_en && addr == A_MCLR) mask <= mask & ~wdata[NCMP-1:0];
    end
  end

  assign irq = |(flags & mask);

  always_comb begin
    rdata = '0;
    case (addr)
      A_RC:   rdata = DW'(rc);
      A_PCNT: rdata = DW'(pcnt);
      A_MCNT: rdata = DW'(mcnt);
      A_STAT: rdata = DW'(flags);
      A_MASK: rdata = DW'(mask);
      default: begin
        for (int i = 0; i < NCMP; i++)
          if (addr == A_CMP + AW'(i)) rdata = DW'(cmp[i]);
      end
    endcase
  end

  // R4
  main_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mcnt != $past(mcnt)) && !$past(mtrig) |-> (mcnt == $past(mcnt) + 1'b1) && $past(tog) && !$past(tog_d));
  // R3
  rc_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rc) == '0) && ($past(pcnt) == '0) |-> pcnt == '0);
  // R2
  tog_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tog != $past(tog)) |-> $past(ptick) || $past(ptrig));
  // R7
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(stat_rd) |-> ((flags & $past(flags)) == $past(flags)));
  // R12
  stop_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_mctl && wdata[1]) |-> !mrun);
  // R1
  stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(mrun) && !$past(mtrig) |-> $stable(mcnt));
endmodule

// File: tb/tb_chained_timer.sv
module tb_chained_timer;
  localparam int DW = 32, CW = 8, AW = 4;
  localparam int NV = 6;
  localparam int VRC [NV] = '{0, 1, 3, 2, 4, 0};
  localparam int VN  [NV] = '{20, 40, 100, 10, 5, 3};

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0, rdata;
  logic irq;
  int total = 0, bad = 0;
  bit done = 0;

  chained_timer #(.DW(DW), .CW(CW), .AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq));

  always #10 clk = ~clk;

  task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    wr_en = 1'b1; addr = AW'(a); wdata = DW'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic peek(int a, output logic [DW-1:0] v);
    addr = AW'(a); #1 v = rdata;
  endtask

  task automatic rd_stat(output logic [DW-1:0] v);
    rd_en = 1'b1; addr = AW'(8); #1 v = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  function automatic int exp_inc(int rc, int n);
    int p = rc + 1;
    if (n - 1 < 2 * p) return 0;
    return ((n - 1 - 2 * p) / (4 * p) + 1) % (1 << CW);
  endfunction

  task automatic start_run(int rc);
    wr(0, 2); wr(1, rc); wr(3, 4); wr(0, 5);
  endtask

  initial begin
    logic [DW-1:0] v, a0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    peek(7, v); chk("R1 mcnt", v, 0);
    peek(2, v); chk("R1 pcnt", v, 0);
    peek(11, v); chk("R1 mask", v, 0);
    peek(8, v); chk("R1 stat", v, 0);
    chk("R1 irq", irq, 0);
    wr(0, 5); repeat (20) @(negedge clk);
    peek(7, v); chk("R1 stopped main", v, 0);
    wr(0, 2);

    // R4 / R10 vector walk
    for (int k = 0; k < NV; k++) begin
      start_run(VRC[k]);
      rd_en = 1'b1; addr = AW'(7);
      repeat (VN[k] / 2) @(negedge clk);
      rd_en = 1'b0;
      repeat (VN[k] - VN[k] / 2) @(negedge clk);
      peek(7, v); chk("R4 R10 main count", v, exp_inc(VRC[k], VN[k]));
    end

    // R2 prescaler count
    start_run(3);
    repeat (5) @(negedge clk); peek(2, v); chk("R2 pcnt mid", v, 2);
    repeat (3) @(negedge clk); peek(2, v); chk("R2 pcnt reload", v, 0);

    // R3 reload zero
    start_run(0);
    repeat (9) @(negedge clk); peek(2, v); chk("R3 pcnt zero", v, 0);

    // R6 R8 R9 compares and mask
    wr(0, 2); wr(4, 2); wr(5, 3); wr(6, 200); rd_stat(v);
    wr(9, 1);
    start_run(0);
    repeat (16) @(negedge clk);
    peek(7, v); chk("R6 count", v, 4);
    peek(8, v); chk("R6 flags", v, 3);
    chk("R9 irq masked on", irq, 1);
    wr(10, 0); peek(11, v); chk("R8 zero clear ignored", v, 1);
    wr(9, 0); peek(11, v); chk("R8 zero set ignored", v, 1);
    wr(10, 1); peek(11, v); chk("R8 clear", v, 0);
    chk("R9 irq off", irq, 0);
    wr(9, 2); peek(11, v); chk("R8 set", v, 2);
    chk("R9 irq bit1", irq, 1);
    rd_stat(v); chk("R7 read value", v, 3);
    peek(8, v); chk("R7 cleared", v, 0);
    chk("R9 irq after clear", irq, 0);

    // R12 stop wins, R5 start / restart
    wr(3, 3); peek(7, a0);
    repeat (20) @(negedge clk); peek(7, v); chk("R12 frozen", v, a0);
    wr(3, 1); repeat (20) @(negedge clk); peek(7, v);
    chk("R5 start resumes", (v == a0) ? 0 : 1, 1);
    wr(3, 4); peek(7, v); chk("R5 restart zero", v, 0);

    // R7 coincident set and read
    wr(0, 2); wr(5, 200); rd_stat(v);
    start_run(0);
    repeat (6) @(negedge clk);
    rd_stat(v); chk("R7 before hit", v & 1, 0);
    peek(7, v); chk("R7 count at hit", v, 2);
    peek(8, v); chk("R7 flag kept", v & 1, 1);

    // R11 wrap
    wr(0, 2); wr(6, 0); rd_stat(v); wr(10, 7); wr(9, 4);
    start_run(0);
    repeat (1027) @(negedge clk);
    peek(7, v); chk("R11 wrap count", v, exp_inc(0, 1027));
    peek(8, v); chk("R11 zero match", (v >> 2) & 1, 1);
    chk("R11 irq", irq, 1);

    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #3000000;
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule